// File: doc/BRIEF.md
# ECC Error Location Applier

This block finishes the correction step for one sector after an external BCH decoder has found the error positions. The sector buffer holds 512 data bytes and 8 metadata bytes. These live in two separate byte-wide buffers outside the block, and the block corrects them in place. A request names a sector. The block waits until that sector's decode-done bit is set, then reads the sector's 4-bit error count from a packed count word. It then fetches the 13-bit error locations from packed location words, two locations per word.

Each location is split into a byte index and a bit index. The block flips that one bit with a read-modify-write on the data buffer or on the metadata buffer, whichever region the location falls in. A location that falls in the parity area is counted but nothing is written back. When the work is finished, the block pulses `done` and presents the number of corrected bits, or an uncorrectable flag if the count field holds the all-ones value.

The controller has five states. The transitions are:
- `ST_IDLE` goes to `ST_WAIT` when a request is accepted.
- `ST_WAIT` goes to `ST_EVAL` once the sector's decode-done bit is set.
- `ST_EVAL` goes to `ST_DONE` for a count of 0 or 15. For any other count it goes to `ST_FIX`.
- `ST_FIX` handles one location per cycle. It goes to `ST_DONE` after the last location.
- `ST_DONE` pulses `done` and returns to `ST_IDLE`.

Top module: `ecc_loc_fixer`

## Requirements
- R1: After reset, `busy`, `done`, `dbuf_we`, `mbuf_we` and `uncorrectable` are 0, and `fix_total` is 0.
- R2: Sector n's error count is taken from bits 4n+3..4n of `err_counts`. No buffer is written until bit n of `dec_done` is 1. While that bit is 0, the block stays busy.
- R3: A count of 15 marks the sector uncorrectable. The block sets `uncorrectable`, reports `fix_total` = 0, flips no bit, and pulses `done`.
- R4: A count of 0 flips no bit and pulses `done` with `fix_total` = 0 and `uncorrectable` = 0.
- R5: Error i is read from location word i/2 (`loc_addr`). An even i uses bits 12:0 and an odd i uses bits 28:16. Bits 15:13 and 31:29 are ignored. Errors are applied in increasing i, one per cycle.
- R6: A location L below 4096 inverts bit L[2:0] of data byte L>>3 and leaves every other bit of the buffer unchanged.
- R7: A location L from 4096 through 4159 inverts bit L[2:0] of metadata byte (L>>3)-512.
- R8: A location of 4160 or above changes neither buffer.
- R9: For a count c in 1..14, `fix_total` equals c once `done` is pulsed, parity-area locations included.
- R10: `done` is high for exactly one cycle. `fix_total` and `uncorrectable` keep their values until the next request is accepted.
- R11: `start` is ignored while `busy` is high, including the cycle in which `done` is high.
- R12: Repeated locations are applied in sequence, so the second of two identical locations restores the bit, and two locations in one byte both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request correction of sector `sect_sel` |
| sect_sel | input | 3 | Sector index, sampled when a request is accepted |
| dec_done | input | 8 | Per-sector decode-done bits |
| err_counts | input | 32 | Packed 4-bit error counts, sector n at bit 4n |
| loc_addr | output | 3 | Location word index being read |
| loc_word | input | 32 | Location word at `loc_addr` (combinational read) |
| dbuf_addr | output | 9 | Data buffer byte index |
| dbuf_rdata | input | 8 | Data byte at `dbuf_addr` (combinational read) |
| dbuf_we | output | 1 | Data buffer write strobe |
| dbuf_wdata | output | 8 | Corrected data byte |
| mbuf_addr | output | 3 | Metadata buffer byte index |
| mbuf_rdata | input | 8 | Metadata byte at `mbuf_addr` (combinational read) |
| mbuf_we | output | 1 | Metadata buffer write strobe |
| mbuf_wdata | output | 8 | Corrected metadata byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| uncorrectable | output | 1 | Last sector was marked uncorrectable |
| fix_total | output | 4 | Number of errors counted for the last sector |

## Verification
Two things can fall in the same cycle: a new `start` request and the `done` pulse that ends the current request. The bench raises `start` exactly in the cycle where it sees `done`. It then judges that no second operation begins:
- `busy` must stay low afterwards;
- no further `done` may appear;
- the buffers and `fix_total` must stay as the scoreboard predicted.

A second overlap exercises consecutive read-modify-writes to the same byte in back-to-back cycles. In that case each write must see the byte that the previous cycle just wrote.

// File: rtl/efa_pkg.sv
package efa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_EVAL,
        ST_FIX,
        ST_DONE
    } efa_state_t;

    typedef enum logic [1:0] {
        RG_DATA,
        RG_META,
        RG_PARITY
    } efa_region_t;

endpackage

// File: rtl/efa_sector_pick.sv
// Selects the addressed sector's count field and decode-done bit and
// classifies the count.
module efa_sector_pick #(
    parameter int NSECT = 8,
    parameter int CNT_W = 4,
    parameter int SECT_W = $clog2(NSECT)
) (
    input  logic [NSECT*CNT_W-1:0] cnt_word,
    input  logic [NSECT-1:0]       ready_vec,
    input  logic [SECT_W-1:0]      sect,
    output logic [CNT_W-1:0]       cnt,
    output logic                   ready,
    output logic                   is_zero,
    output logic                   is_bad
);
    logic [CNT_W-1:0] fields [NSECT];

    for (genvar g = 0; g < NSECT; g++) begin : g_field
        assign fields[g] = cnt_word[g*CNT_W +: CNT_W];
    end

    assign cnt     = fields[sect];
    assign ready   = ready_vec[sect];
    assign is_zero = (cnt == '0);
    assign is_bad  = (cnt == '1);
endmodule

// File: rtl/efa_loc_split.sv
// Picks one location out of a packed word and maps it to a region,
// a byte address and a bit index.
module efa_loc_split
    import efa_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LOC_W = 13,
    parameter int ODD_SHIFT = 16,
    parameter int SECT_BYTES = 512,
    parameter int META_BYTES = 8,
    parameter int DADDR_W = $clog2(SECT_BYTES),
    parameter int MADDR_W = $clog2(META_BYTES)
) (
    input  logic [WORD_W-1:0]  word,
    input  logic               odd,
    output efa_region_t        region,
    output logic [DADDR_W-1:0] daddr,
    output logic [MADDR_W-1:0] maddr,
    output logic [7:0]         flip_mask
);
    localparam int BYTE_W = LOC_W - 3;
    localparam logic [LOC_W-1:0]  DATA_END = LOC_W'(SECT_BYTES * 8);
    localparam logic [LOC_W-1:0]  META_END = LOC_W'((SECT_BYTES + META_BYTES) * 8);
    localparam logic [BYTE_W-1:0] META_BASE = BYTE_W'(SECT_BYTES);

    logic [LOC_W-1:0]  loc;
    logic [BYTE_W-1:0] byte_idx;
    logic [BYTE_W-1:0] meta_off;
    logic [2:0]        bit_idx;

    assign loc       = odd ? word[ODD_SHIFT +: LOC_W] : word[0 +: LOC_W];
    assign byte_idx  = loc[LOC_W-1:3];
    assign bit_idx   = loc[2:0];
    assign meta_off  = byte_idx - META_BASE;
    assign daddr     = byte_idx[DADDR_W-1:0];
    assign maddr     = meta_off[MADDR_W-1:0];
    assign flip_mask = 8'b1 << bit_idx;

    always_comb begin
        if (loc < DATA_END) begin
            region = RG_DATA;
        end else if (loc < META_END) begin
            region = RG_META;
        end else begin
            region = RG_PARITY;
        end
    end
endmodule

// File: rtl/efa_ctrl.sv
// Sequencer: wait for decode-done, classify the count, walk the locations.
module efa_ctrl
    import efa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       sect_ready,
    input  logic       is_zero,
    input  logic       is_bad,
    input  logic       last_loc,
    output efa_state_t state,
    output logic       accept,
    output logic       eval,
    output logic       step,
    output logic       busy,
    output logic       done_p
);
    efa_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (start)      nxt = ST_WAIT;
            ST_WAIT: if (sect_ready) nxt = ST_EVAL;
            ST_EVAL: nxt = (is_bad || is_zero) ? ST_DONE : ST_FIX;
            ST_FIX:  if (last_loc)   nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = 1'b0;
        eval   = 1'b0;
        step   = 1'b0;
        busy   = 1'b1;
        done_p = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy   = 1'b0;
                accept = start;
            end
            ST_WAIT: ;
            ST_EVAL: eval = 1'b1;
            ST_FIX:  step = 1'b1;
            ST_DONE: done_p = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/ecc_loc_fixer.sv
module ecc_loc_fixer
    import efa_pkg::*;
#(
    parameter int NSECT = 8,
    parameter int CNT_W = 4,
    parameter int WORD_W = 32,
    parameter int LOC_W = 13,
    parameter int ODD_SHIFT = 16,
    parameter int SECT_BYTES = 512,
    parameter int META_BYTES = 8,
    localparam int SECT_W = $clog2(NSECT),
    localparam int LADDR_W = CNT_W - 1,
    localparam int DADDR_W = $clog2(SECT_BYTES),
    localparam int MADDR_W = $clog2(META_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SECT_W-1:0]      sect_sel,
    input  logic [NSECT-1:0]       dec_done,
    input  logic [NSECT*CNT_W-1:0] err_counts,
    output logic [LADDR_W-1:0]     loc_addr,
    input  logic [WORD_W-1:0]      loc_word,
    output logic [DADDR_W-1:0]     dbuf_addr,
    input  logic [7:0]             dbuf_rdata,
    output logic                   dbuf_we,
    output logic [7:0]             dbuf_wdata,
    output logic [MADDR_W-1:0]     mbuf_addr,
    input  logic [7:0]             mbuf_rdata,
    output logic                   mbuf_we,
    output logic [7:0]             mbuf_wdata,
    output logic                   busy,
    output logic                   done,
    output logic                   uncorrectable,
    output logic [CNT_W-1:0]       fix_total
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    efa_state_t       state;
    logic [SECT_W-1:0] sect_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  total_q;
    logic              bad_q;
    logic [CNT_W-1:0]  cnt;
    logic              sect_ready, is_zero, is_bad, last_loc;
    logic              accept, eval, step;
    efa_region_t       region;
    logic [7:0]        flip_mask;

    efa_sector_pick #(.NSECT(NSECT), .CNT_W(CNT_W), .SECT_W(SECT_W)) u_pick (
        .cnt_word (err_counts),
        .ready_vec(dec_done),
        .sect     (sect_q),
        .cnt      (cnt),
        .ready    (sect_ready),
        .is_zero  (is_zero),
        .is_bad   (is_bad)
    );

    efa_loc_split #(
        .WORD_W(WORD_W), .LOC_W(LOC_W), .ODD_SHIFT(ODD_SHIFT),
        .SECT_BYTES(SECT_BYTES), .META_BYTES(META_BYTES),
        .DADDR_W(DADDR_W), .MADDR_W(MADDR_W)
    ) u_split (
        .word     (loc_word),
        .odd      (idx_q[0]),
        .region   (region),
        .daddr    (dbuf_addr),
        .maddr    (mbuf_addr),
        .flip_mask(flip_mask)
    );

    assign last_loc = (idx_q == cnt - ONE);

    efa_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .sect_ready(sect_ready),
        .is_zero   (is_zero),
        .is_bad    (is_bad),
        .last_loc  (last_loc),
        .state     (state),
        .accept    (accept),
        .eval      (eval),
        .step      (step),
        .busy      (busy),
        .done_p    (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sect_q  <= '0;
            idx_q   <= '0;
            total_q <= '0;
            bad_q   <= 1'b0;
        end else begin
            if (accept) begin
                sect_q  <= sect_sel;
                idx_q   <= '0;
                total_q <= '0;
                bad_q   <= 1'b0;
            end
            if (eval && is_bad) begin
                bad_q <= 1'b1;
            end
            if (step) begin
                idx_q   <= idx_q + ONE;
                total_q <= total_q + ONE;
            end
        end
    end

    assign loc_addr      = idx_q[CNT_W-1:1];
    assign dbuf_we       = step && (region == RG_DATA);
    assign mbuf_we       = step && (region == RG_META);
    assign dbuf_wdata    = dbuf_rdata ^ flip_mask;
    assign mbuf_wdata    = mbuf_rdata ^ flip_mask;
    assign fix_total     = total_q;
    assign uncorrectable = bad_q;

    logic unused_state;
    assign unused_state = ^state;
endmodule

// File: rtl/efa_checker.sv
module efa_checker #(
    parameter int NSECT = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [NSECT-1:0] dec_done,
    input logic             dbuf_we,
    input logic             mbuf_we,
    input logic             busy,
    input logic             done,
    input logic             uncorrectable,
    input logic [CNT_W-1:0] fix_total
);
    p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |-> !dbuf_we && !mbuf_we);

    p_write_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dbuf_we || mbuf_we) |-> busy && (dec_done != '0));

    p_bad_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && uncorrectable) |-> fix_total == '0);

    p_one_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dbuf_we && mbuf_we));

    p_total_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !uncorrectable) |-> fix_total != '1);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(fix_total) && $stable(uncorrectable));

    p_stay_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

bind ecc_loc_fixer efa_checker #(.NSECT(NSECT), .CNT_W(CNT_W)) u_efa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .dec_done     (dec_done),
    .dbuf_we      (dbuf_we),
    .mbuf_we      (mbuf_we),
    .busy         (busy),
    .done         (done),
    .uncorrectable(uncorrectable),
    .fix_total    (fix_total)
);

// File: tb/ecc_loc_fixer_test.sv
module ecc_loc_fixer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  sect_sel = '0;
    logic [7:0]  dec_done = '1;
    logic [31:0] err_counts = 32'h9C7B_35D6;
    logic [2:0]  loc_addr;
    logic [31:0] loc_word;
    logic [8:0]  dbuf_addr;
    logic [7:0]  dbuf_rdata, dbuf_wdata;
    logic        dbuf_we;
    logic [2:0]  mbuf_addr;
    logic [7:0]  mbuf_rdata, mbuf_wdata;
    logic        mbuf_we;
    logic        busy, done, uncorrectable;
    logic [3:0]  fix_total;

    always #2 clk = ~clk;

    logic [7:0]  dmem [512];
    logic [7:0]  mmem [8];
    logic [7:0]  exp_d [512];
    logic [7:0]  exp_m [8];
    logic [31:0] locw [8];
    int          loc_list [16];

    assign loc_word   = locw[loc_addr];
    assign dbuf_rdata = dmem[dbuf_addr];
    assign mbuf_rdata = mmem[mbuf_addr];

    always @(posedge clk) begin
        if (dbuf_we) dmem[dbuf_addr] <= dbuf_wdata;
        if (mbuf_we) mmem[mbuf_addr] <= mbuf_wdata;
    end

    ecc_loc_fixer uut (
        .clk(clk), .rst_n(rst_n), .start(start), .sect_sel(sect_sel),
        .dec_done(dec_done), .err_counts(err_counts), .loc_addr(loc_addr),
        .loc_word(loc_word), .dbuf_addr(dbuf_addr), .dbuf_rdata(dbuf_rdata),
        .dbuf_we(dbuf_we), .dbuf_wdata(dbuf_wdata), .mbuf_addr(mbuf_addr),
        .mbuf_rdata(mbuf_rdata), .mbuf_we(mbuf_we), .mbuf_wdata(mbuf_wdata),
        .busy(busy), .done(done), .uncorrectable(uncorrectable),
        .fix_total(fix_total)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;
    int writes_seen = 0;
    int dones_seen = 0;

    typedef struct packed {
        logic [3:0] total;
        logic       bad;
    } exp_t;
    exp_t  exp_q [$];
    string tag_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (dbuf_we || mbuf_we)) writes_seen++;
        if (rst_n && done) begin
            exp_t  e;
            string t;
            dones_seen++;
            if (exp_q.size() == 0) begin
                chk(0, "R11 unexpected done", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(fix_total == e.total, {t, " fix_total"}, int'(fix_total), int'(e.total));
                chk(uncorrectable == e.bad, {t, " uncorrectable"}, int'(uncorrectable), int'(e.bad));
            end
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    task automatic cmp_buffers(input string tag);
        int bad = 0;
        for (int i = 0; i < 512; i++) if (dmem[i] !== exp_d[i]) bad++;
        for (int i = 0; i < 8; i++) if (mmem[i] !== exp_m[i]) bad++;
        chk(bad == 0, {tag, " buffer mismatches"}, bad, 0);
    endtask

    // driver: program the sector, predict, push to scoreboard, run
    task automatic run_case(input int sect, input int cnt, input string tag,
                            input bit hold_ready, input bit poke_at_done);
        int total;
        int w0;
        err_counts[sect*4 +: 4] = 4'(cnt);
        for (int i = 0; i < 8; i++) locw[i] = 32'hFFFF_FFFF;
        for (int i = 0; i < 14; i++)
            locw[i/2][(i%2)*16 +: 13] = 13'(loc_list[i]);
        total = 0;
        if (cnt != 15) begin
            for (int i = 0; i < cnt; i++) begin
                int l = loc_list[i];
                if (l < 4096) exp_d[l >> 3] ^= 8'(1 << (l & 7));
                else if (l < 4160) exp_m[(l >> 3) - 512] ^= 8'(1 << (l & 7));
                total++;
            end
        end
        exp_q.push_back('{total: 4'(total), bad: (cnt == 15)});
        tag_q.push_back(tag);
        if (hold_ready) dec_done[sect] = 1'b0;
        w0 = writes_seen;
        @(negedge clk);
        sect_sel = 3'(sect);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (hold_ready) begin
            repeat (6) @(negedge clk);
            chk(busy == 1'b1, "R2 busy while decode pending", int'(busy), 1);
            chk(writes_seen == w0, "R2 no write before decode-done", writes_seen - w0, 0);
            dec_done[sect] = 1'b1;
        end
        while (!done) @(negedge clk);
        if (poke_at_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_at_done) begin
            int d0 = dones_seen;
            repeat (4) begin
                chk(busy == 1'b0, "R11 start in done cycle ignored", int'(busy), 0);
                @(negedge clk);
            end
            chk(dones_seen == d0, "R11 no extra done", dones_seen - d0, 0);
            chk(fix_total == 4'(total), "R10 result held", int'(fix_total), total);
        end
        cmp_buffers(tag);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) begin
            dmem[i] = 8'(i * 37 + 5);
            exp_d[i] = dmem[i];
        end
        for (int i = 0; i < 8; i++) begin
            mmem[i] = 8'(i * 91 + 3);
            exp_m[i] = mmem[i];
        end
        for (int i = 0; i < 16; i++) loc_list[i] = 0;
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0, "R1 reset busy/done", int'({busy, done}), 0);
        chk(dbuf_we == 0 && mbuf_we == 0, "R1 reset write strobes", int'({dbuf_we, mbuf_we}), 0);
        chk(fix_total == 0 && uncorrectable == 0, "R1 reset results", int'(fix_total), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6 R5: single data error in sector 0
        loc_list[0] = 10;
        run_case(0, 1, "R6 single data flip", 0, 0);

        // R5 R7 R8 R9: mixed regions, odd/even halves
        loc_list[0] = 4095; loc_list[1] = 4096 + 13; loc_list[2] = 4200; loc_list[3] = 333;
        run_case(3, 4, "R7 R8 R9 mixed regions", 0, 0);

        // R3: uncorrectable, locations present but ignored
        loc_list[0] = 1; loc_list[1] = 4100; loc_list[2] = 77;
        run_case(5, 15, "R3 uncorrectable", 0, 0);

        // R4: zero count
        loc_list[0] = 50;
        run_case(2, 0, "R4 zero count", 0, 0);

        // R12: full list with repeats, same byte, extremes
        loc_list[0] = 100;  loc_list[1] = 101;  loc_list[2] = 100;  loc_list[3] = 4097;
        loc_list[4] = 4097; loc_list[5] = 4103; loc_list[6] = 5000; loc_list[7] = 0;
        loc_list[8] = 7;    loc_list[9] = 8191; loc_list[10] = 4159; loc_list[11] = 4160;
        loc_list[12] = 2048; loc_list[13] = 2049;
        run_case(7, 14, "R12 R5 repeated locations", 0, 0);

        // R2: decode-done pending
        loc_list[0] = 4090; loc_list[1] = 4150;
        run_case(6, 2, "R2 wait for decode", 1, 0);

        // R11 R10: start raised in the done cycle
        loc_list[0] = 12; loc_list[1] = 4130; loc_list[2] = 6000;
        run_case(1, 3, "R11 start at done", 0, 1);

        chk(exp_q.size() == 0, "R10 every request completed once", exp_q.size(), 0);
        summary();
    end
endmodule